// File: doc/BRIEF.md
# Interrupt Presenter with Priority Arbitration

This block sits between a set of interrupt source units and one processor. It holds at most one pending interrupt, together with the processor's current priority and the priority of an inter-processor interrupt (IPI) request. Source units offer interrupts as a source number and a priority. The presenter either latches an offer or sends it back to its unit as a reject. When a new offer displaces a pending interrupt, the displaced interrupt is rejected to the unit that owned it, and that unit redelivers it after a later resend request.

The processor uses a small operation port. It can accept the pending interrupt, set its own priority, set the IPI priority, or signal end of interrupt. The presenter drives one level-sensitive interrupt line and issues single-cycle reject, EOI and resend pulses back toward the source units. Lower priority values are more favoured. A pending priority of 0xFF, or a source field of zero, means nothing is pending.

Top module: `int_presenter`

## Requirements
- R1: After reset the interrupt line is low and no pulse is issued. The processor priority is 0x00, nothing is pending, and the IPI priority is 0xFF. An accept issued straight after reset therefore returns 0x00000000.
- R2: When no operation is issued, an offer is rejected back to its own unit in the next cycle (`reject_src` = offered number, `reject_unit` = offering unit) if either of two conditions holds: its priority is greater than or equal to the processor priority, or an interrupt is already pending at a priority less than or equal to the offer's priority. In that case the pending state is unchanged.
- R3: An offer that is not rejected is latched (source number and priority) and the line goes high in the next cycle. If another interrupt with an owning unit was pending, that interrupt is rejected to its owner in the same cycle. A pending IPI is dropped without a reject.
- R4: Accept (`op_kind` 2'b00) pulses `acc_valid` with `acc_data` = {processor priority[31:24], pending source[23:0]} and lowers the line. It then makes the processor priority equal to the old pending priority, clears the pending source, and sets the pending priority to 0xFF.
- R5: Writing the IPI priority (`op_kind` 2'b10, value in `op_data[7:0]`) stores it. If the value is below the processor priority, and no interrupt is pending at a priority less than or equal to it, the block rejects any owned pending interrupt. It then makes source number 2 pending at that priority and raises the line.
- R6: Writing a processor priority (`op_kind` 2'b01, value in `op_data[7:0]`) that is below the current one, while an interrupt is pending at a priority greater than or equal to the new value, withdraws that interrupt. The line goes low, nothing stays pending, and the interrupt is rejected to its owner if it has one.
- R7: Writing a processor priority that is not below the current one while nothing is pending causes a resend. `resend_valid` pulses, and if the IPI priority is below the new processor priority, the IPI becomes pending and the line rises.
- R8: An EOI (`op_kind` 2'b11) copies `op_data[31:24]` into the processor priority and pulses `eoi_valid` with `eoi_src` = `op_data[23:0]`. If nothing is pending it also performs the resend of R7, judged against the new processor priority.
- R9: An offer in the same cycle as an operation is ignored: it produces no reject and leaves the pending interrupt unchanged.
- R10: Reject, EOI, resend and accept outputs are single-cycle pulses. They are low in any cycle following a cycle with no operation and no offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Processor operation strobe |
| op_kind | input | 2 | 00 accept, 01 processor priority, 10 IPI priority, 11 EOI |
| op_data | input | 32 | Operation value |
| offer_valid | input | 1 | Delivery offer strobe |
| offer_src | input | 24 | Offered source number (non-zero) |
| offer_prio | input | 8 | Offered priority |
| offer_unit | input | UNIT_W | Index of the offering source unit |
| irq_out | output | 1 | Interrupt level to the processor |
| acc_valid | output | 1 | Accept result strobe |
| acc_data | output | 32 | Pending register value returned by accept |
| reject_valid | output | 1 | Reject pulse |
| reject_src | output | 24 | Rejected source number |
| reject_unit | output | UNIT_W | Unit that receives the reject |
| eoi_valid | output | 1 | EOI broadcast pulse |
| eoi_src | output | 24 | Source number being ended |
| resend_valid | output | 1 | Resend broadcast pulse |

## Verification
The assertions assume two things about offers: every offered source number is non-zero, and an offer that collides with an operation is simply lost. They also assume that the operation codes cover every case. The random stimulus only draws offer numbers from a non-zero range. It keeps processor priority writes high enough that offers are often taken, so displacement, withdrawal and IPI preemption all occur. Deliberate collisions between offers and operations appear only in directed steps, where the lost offer is checked at the reject port and through a later accept.

// File: rtl/int_presenter.sv
module int_presenter #(
  parameter int UNIT_W = 2,
  parameter logic [23:0] IPI_NUM = 24'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [31:0]       op_data,
  input  logic              offer_valid,
  input  logic [23:0]       offer_src,
  input  logic [7:0]        offer_prio,
  input  logic [UNIT_W-1:0] offer_unit,
  output logic              irq_out,
  output logic              acc_valid,
  output logic [31:0]       acc_data,
  output logic              reject_valid,
  output logic [23:0]       reject_src,
  output logic [UNIT_W-1:0] reject_unit,
  output logic              eoi_valid,
  output logic [23:0]       eoi_src,
  output logic              resend_valid
);

  localparam logic [1:0] OP_ACC  = 2'b00;
  localparam logic [1:0] OP_CPPR = 2'b01;
  localparam logic [1:0] OP_IPI  = 2'b10;
  localparam logic [1:0] OP_EOI  = 2'b11;
  localparam logic [7:0] IDLE_PRIO = 8'hFF;

  logic [7:0]        cppr, pend, ipi_prio;
  logic [23:0]       xisr;
  logic              own_vld;
  logic [UNIT_W-1:0] own_unit;

  logic [7:0]        n_cppr, n_pend, n_ipi, rs_cppr;
  logic [23:0]       n_xisr;
  logic              n_own_vld, n_irq, do_rs;
  logic [UNIT_W-1:0] n_own_unit;
  logic              n_acc_v, n_rej_v, n_eoi_v, n_res_v;
  logic [31:0]       n_acc_d;
  logic [23:0]       n_rej_s, n_eoi_s;
  logic [UNIT_W-1:0] n_rej_u;

  wire       busy = xisr != 24'd0;
  wire [7:0] wval = op_data[7:0];

  always_comb begin
    n_cppr = cppr; n_pend = pend; n_ipi = ipi_prio; n_xisr = xisr;
    n_own_vld = own_vld; n_own_unit = own_unit; n_irq = irq_out;
    n_acc_v = 1'b0; n_acc_d = acc_data;
    n_rej_v = 1'b0; n_rej_s = reject_src; n_rej_u = reject_unit;
    n_eoi_v = 1'b0; n_eoi_s = eoi_src; n_res_v = 1'b0;
    do_rs = 1'b0; rs_cppr = cppr;
    if (op_valid) begin
      case (op_kind)
        OP_ACC: begin
          n_acc_v = 1'b1; n_acc_d = {cppr, xisr};
          n_irq = 1'b0; n_cppr = pend; n_xisr = 24'd0;
          n_pend = IDLE_PRIO; n_own_vld = 1'b0;
        end
        OP_CPPR: begin
          n_cppr = wval;
          if (wval < cppr) begin
            if (busy && wval <= pend) begin
              n_xisr = 24'd0; n_pend = IDLE_PRIO; n_irq = 1'b0; n_own_vld = 1'b0;
              if (own_vld) begin
                n_rej_v = 1'b1; n_rej_s = xisr; n_rej_u = own_unit;
              end
            end
          end else if (!busy) begin
            do_rs = 1'b1; rs_cppr = wval;
          end
        end
        OP_IPI: begin
          n_ipi = wval;
          if (wval < cppr && !(busy && pend <= wval)) begin
            if (busy && own_vld) begin
              n_rej_v = 1'b1; n_rej_s = xisr; n_rej_u = own_unit;
            end
            n_xisr = IPI_NUM; n_pend = wval; n_own_vld = 1'b0; n_irq = 1'b1;
          end
        end
        OP_EOI: begin
          n_cppr = op_data[31:24];
          n_eoi_v = 1'b1; n_eoi_s = op_data[23:0];
          if (!busy) begin
            do_rs = 1'b1; rs_cppr = op_data[31:24];
          end
        end
      endcase
    end else if (offer_valid) begin
      if (offer_prio >= cppr || (busy && pend <= offer_prio)) begin
        n_rej_v = 1'b1; n_rej_s = offer_src; n_rej_u = offer_unit;
      end else begin
        if (busy && own_vld) begin
          n_rej_v = 1'b1; n_rej_s = xisr; n_rej_u = own_unit;
        end
        n_xisr = offer_src; n_pend = offer_prio;
        n_own_vld = 1'b1; n_own_unit = offer_unit; n_irq = 1'b1;
      end
    end
    if (do_rs) begin
      n_res_v = 1'b1;
      if (ipi_prio < rs_cppr) begin
        n_xisr = IPI_NUM; n_pend = ipi_prio; n_own_vld = 1'b0; n_irq = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr <= 8'h00; pend <= IDLE_PRIO; ipi_prio <= IDLE_PRIO; xisr <= 24'd0;
      own_vld <= 1'b0; own_unit <= '0; irq_out <= 1'b0;
      acc_valid <= 1'b0; acc_data <= 32'd0;
      reject_valid <= 1'b0; reject_src <= 24'd0; reject_unit <= '0;
      eoi_valid <= 1'b0; eoi_src <= 24'd0; resend_valid <= 1'b0;
    end else begin
      cppr <= n_cppr; pend <= n_pend; ipi_prio <= n_ipi; xisr <= n_xisr;
      own_vld <= n_own_vld; own_unit <= n_own_unit; irq_out <= n_irq;
      acc_valid <= n_acc_v; acc_data <= n_acc_d;
      reject_valid <= n_rej_v; reject_src <= n_rej_s; reject_unit <= n_rej_u;
      eoi_valid <= n_eoi_v; eoi_src <= n_eoi_s; resend_valid <= n_res_v;
    end
  end

  p_accept_drops_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_ACC) |=> (acc_valid && !irq_out && xisr == 24'd0));

  p_offer_bounced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !op_valid && offer_prio >= cppr)
      |=> (reject_valid && reject_src == $past(offer_src) && reject_unit == $past(offer_unit)));

  p_ipi_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_IPI && !busy && op_data[7:0] < cppr)
      |=> (irq_out && xisr == IPI_NUM));

  p_eoi_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_EOI) |=> (eoi_valid && eoi_src == $past(op_data[23:0])));

  p_quiet_pulses_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !offer_valid) |=> !(acc_valid || reject_valid || eoi_valid || resend_valid));

endmodule

// File: tb/int_presenter_tb_top.sv
`timescale 1ns/1ps
module int_presenter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic [31:0] op_data = 32'd0;
  logic offer_valid = 1'b0;
  logic [23:0] offer_src = 24'd0;
  logic [7:0] offer_prio = 8'd0;
  logic [1:0] offer_unit = 2'd0;
  logic irq_out, acc_valid, reject_valid, eoi_valid, resend_valid;
  logic [31:0] acc_data;
  logic [23:0] reject_src, eoi_src;
  logic [1:0] reject_unit;

  int total = 0;
  int bad = 0;

  logic [7:0] m_cppr, m_pend, m_ipi;
  logic [23:0] m_xisr;
  logic m_own_vld, e_irq, e_acc_v, e_rej_v, e_eoi_v, e_res_v;
  logic [1:0] m_own_unit, e_rej_u;
  logic [31:0] e_acc_d;
  logic [23:0] e_rej_s, e_eoi_s;

  always #4 clk = ~clk;

  int_presenter #(.UNIT_W(2), .IPI_NUM(24'd2)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_data(op_data),
    .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio), .offer_unit(offer_unit),
    .irq_out(irq_out), .acc_valid(acc_valid), .acc_data(acc_data),
    .reject_valid(reject_valid), .reject_src(reject_src), .reject_unit(reject_unit),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_valid(resend_valid));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cppr = 8'h00; m_pend = 8'hFF; m_ipi = 8'hFF; m_xisr = 24'd0;
    m_own_vld = 1'b0; m_own_unit = 2'd0; e_irq = 1'b0;
  endtask

  task automatic reject_to(input logic [23:0] s, input logic [1:0] u);
    e_rej_v = 1'b1; e_rej_s = s; e_rej_u = u;
  endtask

  task automatic model(input logic ov, input logic [1:0] k, input logic [31:0] d,
                       input logic fv, input logic [23:0] s, input logic [7:0] p, input logic [1:0] u);
    logic rs;
    logic [7:0] rc;
    logic pending;
    rs = 1'b0; rc = 8'h00; pending = (m_xisr != 0);
    e_acc_v = 0; e_rej_v = 0; e_eoi_v = 0; e_res_v = 0;
    if (ov) begin
      if (k == 2'b00) begin
        e_acc_v = 1; e_acc_d = {m_cppr, m_xisr}; e_irq = 0;
        m_cppr = m_pend; m_xisr = 0; m_pend = 8'hFF; m_own_vld = 0;
      end else if (k == 2'b01) begin
        if (d[7:0] < m_cppr) begin
          if (pending && d[7:0] <= m_pend) begin
            if (m_own_vld) reject_to(m_xisr, m_own_unit);
            m_xisr = 0; m_pend = 8'hFF; e_irq = 0; m_own_vld = 0;
          end
        end else if (!pending) begin
          rs = 1; rc = d[7:0];
        end
        m_cppr = d[7:0];
      end else if (k == 2'b10) begin
        m_ipi = d[7:0];
        if (d[7:0] < m_cppr && !(pending && m_pend <= d[7:0])) begin
          if (pending && m_own_vld) reject_to(m_xisr, m_own_unit);
          m_xisr = 24'd2; m_pend = d[7:0]; m_own_vld = 0; e_irq = 1;
        end
      end else begin
        m_cppr = d[31:24]; e_eoi_v = 1; e_eoi_s = d[23:0];
        if (!pending) begin rs = 1; rc = d[31:24]; end
      end
    end else if (fv) begin
      if (p >= m_cppr || (pending && m_pend <= p)) reject_to(s, u);
      else begin
        if (pending && m_own_vld) reject_to(m_xisr, m_own_unit);
        m_xisr = s; m_pend = p; m_own_vld = 1; m_own_unit = u; e_irq = 1;
      end
    end
    if (rs) begin
      e_res_v = 1;
      if (m_ipi < rc) begin
        m_xisr = 24'd2; m_pend = m_ipi; m_own_vld = 0; e_irq = 1;
      end
    end
  endtask

  function automatic logic [86:0] pack(input logic i, input logic av, input logic [31:0] ad,
      input logic rv, input logic [23:0] rsrc, input logic [1:0] ru,
      input logic ev, input logic [23:0] es, input logic sv);
    return {i, av, av ? ad : 32'd0, rv, rv ? {rsrc, ru} : 26'd0, ev, ev ? es : 24'd0, sv};
  endfunction

  task automatic step(input string req, input logic ov, input logic [1:0] k, input logic [31:0] d,
                      input logic fv, input logic [23:0] s, input logic [7:0] p, input logic [1:0] u);
    logic [86:0] a, e;
    op_valid = ov; op_kind = k; op_data = d;
    offer_valid = fv; offer_src = s; offer_prio = p; offer_unit = u;
    model(ov, k, d, fv, s, p, u);
    @(posedge clk);
    @(negedge clk);
    a = pack(irq_out, acc_valid, acc_data, reject_valid, reject_src, reject_unit, eoi_valid, eoi_src, resend_valid);
    e = pack(e_irq, e_acc_v, e_acc_d, e_rej_v, e_rej_s, e_rej_u, e_eoi_v, e_eoi_s, e_res_v);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic idle();
    step("R10", 0, 2'b00, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", {irq_out, acc_valid, reject_valid, eoi_valid, resend_valid}, 0);
    step("R1", 1, 2'b00, 0, 0, 0, 0, 0);
    chk("R1", {acc_valid, acc_data}, {1'b1, 32'h0});
    step("R3", 0, 2'b00, 0, 1, 24'd5, 8'h10, 2'd1);
    chk("R3", irq_out, 1);
    step("R2", 0, 2'b00, 0, 1, 24'd6, 8'h10, 2'd3);
    chk("R2", {reject_valid, reject_src, reject_unit}, {1'b1, 24'd6, 2'd3});
    step("R3", 0, 2'b00, 0, 1, 24'd7, 8'h08, 2'd2);
    chk("R3", {irq_out, reject_valid, reject_src, reject_unit}, {1'b1, 1'b1, 24'd5, 2'd1});
    step("R9", 1, 2'b10, 32'hFF, 1, 24'd9, 8'h00, 2'd0);
    chk("R9", reject_valid, 0);
    step("R4", 1, 2'b00, 0, 0, 0, 0, 0);
    chk("R4", {irq_out, acc_data}, {1'b0, 8'hFF, 24'd7});
    step("R6", 1, 2'b01, 32'h04, 0, 0, 0, 0);
    step("R5", 1, 2'b10, 32'h02, 0, 0, 0, 0);
    chk("R5", irq_out, 1);
    step("R4", 1, 2'b00, 0, 0, 0, 0, 0);
    chk("R4", acc_data, {8'h04, 24'd2});
    step("R8", 1, 2'b11, {8'hFF, 24'd2}, 0, 0, 0, 0);
    chk("R8", {eoi_valid, eoi_src, resend_valid, irq_out}, {1'b1, 24'd2, 1'b1, 1'b1});
    step("R4", 1, 2'b00, 0, 0, 0, 0, 0);
    step("R5", 1, 2'b10, 32'hFF, 0, 0, 0, 0);
    step("R8", 1, 2'b11, {8'hFF, 24'd2}, 0, 0, 0, 0);
    chk("R8", {resend_valid, irq_out}, {1'b1, 1'b0});
    step("R3", 0, 2'b00, 0, 1, 24'd9, 8'h30, 2'd3);
    step("R6", 1, 2'b01, 32'h20, 0, 0, 0, 0);
    chk("R6", {irq_out, reject_valid, reject_src, reject_unit}, {1'b0, 1'b1, 24'd9, 2'd3});
    step("R7", 1, 2'b01, 32'h40, 0, 0, 0, 0);
    chk("R7", {resend_valid, irq_out}, {1'b1, 1'b0});
    idle();
    chk("R10", {acc_valid, reject_valid, eoi_valid, resend_valid}, 0);
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 10) idle();
      else if (r < 20) step("R4", 1, 2'b00, 0, 0, 0, 0, 0);
      else if (r < 30) step("R6", 1, 2'b01, {24'd0, 8'($urandom_range(8'h40, 8'hFF))}, 0, 0, 0, 0);
      else if (r < 37) step("R5", 1, 2'b10, {24'd0, 8'($urandom_range(0, 8'hFF))}, 0, 0, 0, 0);
      else if (r < 45) step("R8", 1, 2'b11, {8'($urandom_range(8'h40, 8'hFF)), 24'($urandom_range(1, 60))}, 0, 0, 0, 0);
      else step("R3", 0, 2'b00, 0, 1, 24'($urandom_range(1, 60)), 8'($urandom_range(0, 8'h90)), 2'($urandom_range(0, 3)));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule